// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire serial sampling converter that returns 14-bit results with no pipeline delay. When the system asks for a sample, the controller raises the convert line and holds it for the converter's conversion time. It then lowers the line, waits a short setup interval, and drives a serial clock. It shifts in the result most significant bit first and delivers the assembled word with a one-cycle valid strobe.

The converter presents its most significant bit as soon as the convert line falls. For this reason only thirteen falling clock edges are needed to step through the remaining bits. The serial clock idles high and stays static during the conversion. All timing is counted in system-clock cycles through parameters. A throughput window blocks a new conversion until the minimum sample period has passed since the previous convert rising edge. The result is straight binary: code 0 is zero volts and each LSB is the reference voltage divided by 2^14.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, conv_o is 0, sck_o is 1, valid_o is 0, ready_o is 1 and data_o is 0.
- R2: Once a start request is accepted, conv_o rises on the next clock edge and stays high for exactly CONV_CYC cycles.
- R3: sck_o stays high for the whole time conv_o is high. The first sck_o edge, a falling one, comes exactly SETUP_CYC cycles after conv_o falls.
- R4: Each transaction produces exactly DATA_W-1 falling edges on sck_o. Every low phase and every high phase between them lasts SCK_HALF cycles, and sck_o ends high.
- R5: The MSB is sampled from sdo_i on the clock edge that makes the first sck_o falling edge. Each further bit is sampled on the edge that raises sck_o. data_o holds the bits in arrival order, first bit at bit DATA_W-1, so the all-zero, all-one and mixed codes are returned unchanged.
- R6: valid_o is a single-cycle pulse. It comes exactly SETUP_CYC + (2*DATA_W-3)*SCK_HALF + QUIET_CYC cycles after conv_o falls, and data_o keeps the result until the next pulse.
- R7: ready_o falls when a start request is accepted. A start request while ready_o is low has no effect. Two conv_o rising edges are at least CYCLE_MIN cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample request, accepted when ready_o is high |
| ready_o | output | 1 | Controller can accept a new request |
| conv_o | output | 1 | Convert line to the converter |
| sck_o | output | 1 | Serial clock to the converter, idles high |
| sdo_i | input | 1 | Serial data from the converter |
| data_o | output | DATA_W | Last assembled result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A converter model drives sdo_i from a chosen word. It presents the MSB on the convert falling edge, then one bit per sck falling edge, then zeros. The words tried are all zeros, all ones, alternating patterns of both phases, and words with only the top or only the bottom bit set. These show whether bit order is reversed, whether the MSB capture is missed, and whether a trailing zero slips in. Start requests are also issued in the middle of a transaction and right after a result, to separate a correct throughput guard from one that lets a second conversion start early. Each transaction also measures the convert pulse length, the setup-to-strobe latency and the number of clock falls.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W    = 14,
  parameter int CONV_CYC  = 325,
  parameter int SETUP_CYC = 3,
  parameter int SCK_HALF  = 7,
  parameter int QUIET_CYC = 4,
  parameter int CYCLE_MIN = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              ready_o,
  output logic              conv_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int M1     = (CONV_CYC > SETUP_CYC) ? CONV_CYC : SETUP_CYC;
  localparam int M2     = (SCK_HALF > QUIET_CYC) ? SCK_HALF : QUIET_CYC;
  localparam int CNT_W  = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam int TP_W   = $clog2(CYCLE_MIN + 1);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam logic [TP_W-1:0]  TP_LAST   = TP_W'(CYCLE_MIN - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 2);
  localparam logic [CNT_W-1:0] CONV_END  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_END  = CNT_W'(SCK_HALF - 1);
  localparam logic [CNT_W-1:0] QUIET_END = CNT_W'(QUIET_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_SETUP, S_LO, S_HI, S_QUIET} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   nbit;
  logic [TP_W-1:0]    tput;
  logic [DATA_W-1:0]  shreg, data_q;
  logic               conv_q, sck_q, valid_q;
  logic               accept, cnt_done;

  assign ready_o = (st == S_IDLE) && (tput == TP_LAST);
  assign accept  = ready_o && start_i;
  assign conv_o  = conv_q;
  assign sck_o   = sck_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_comb begin
    case (st)
      S_CONV:  cnt_done = (cnt == CONV_END);
      S_SETUP: cnt_done = (cnt == SETUP_END);
      S_LO,
      S_HI:    cnt_done = (cnt == HALF_END);
      S_QUIET: cnt_done = (cnt == QUIET_END);
      default: cnt_done = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      tput    <= TP_LAST;
      shreg   <= '0;
      data_q  <= '0;
      conv_q  <= 1'b0;
      sck_q   <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept)                tput <= '0;
      else if (tput != TP_LAST)  tput <= tput + 1'b1;

      if (st != S_IDLE) cnt <= cnt_done ? '0 : cnt + 1'b1;

      case (st)
        S_IDLE: if (accept) begin
          st     <= S_CONV;
          conv_q <= 1'b1;
          cnt    <= '0;
        end
        S_CONV: if (cnt_done) begin
          st     <= S_SETUP;
          conv_q <= 1'b0;
        end
        S_SETUP: if (cnt_done) begin
          shreg <= {shreg[DATA_W-2:0], sdo_i};
          sck_q <= 1'b0;
          nbit  <= '0;
          st    <= S_LO;
        end
        S_LO: if (cnt_done) begin
          shreg <= {shreg[DATA_W-2:0], sdo_i};
          sck_q <= 1'b1;
          nbit  <= nbit + 1'b1;
          st    <= (nbit == LAST_BIT) ? S_QUIET : S_HI;
        end
        S_HI: if (cnt_done) begin
          sck_q <= 1'b0;
          st    <= S_LO;
        end
        S_QUIET: if (cnt_done) begin
          data_q  <= shreg;
          valid_q <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int CONV_CYC = 325,
  parameter int SCK_HALF = 7
) (
  input logic clk,
  input logic rst_n,
  input logic ready_o,
  input logic conv_o,
  input logic sck_o,
  input logic valid_o
);
  logic [31:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= conv_o ? hi_cnt + 1 : '0;
      lo_cnt <= sck_o ? '0 : lo_cnt + 1;
    end
  end

  a_r2_conv_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> hi_cnt == CONV_CYC);
  a_r3_sck_static: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> sck_o);
  a_r3_no_edge_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> !conv_o);
  a_r4_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> lo_cnt == SCK_HALF);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r7_guarded_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> $past(ready_o));
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> !ready_o);
endmodule

bind adc_serial_reader adc_serial_reader_chk #(
  .CONV_CYC(CONV_CYC),
  .SCK_HALF(SCK_HALF)
) i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ready_o(ready_o),
  .conv_o(conv_o),
  .sck_o(sck_o),
  .valid_o(valid_o)
);

// File: tb/test_adc_serial_reader.sv
module test_adc_serial_reader;
  localparam int DATA_W    = 14;
  localparam int CONV_CYC  = 325;
  localparam int SETUP_CYC = 3;
  localparam int SCK_HALF  = 7;
  localparam int QUIET_CYC = 4;
  localparam int CYCLE_MIN = 600;
  localparam int LAT = SETUP_CYC + (2*DATA_W-3)*SCK_HALF + QUIET_CYC;

  logic clk = 0, rst_n = 0, start_i = 0, sdo_i = 0;
  logic ready_o, conv_o, sck_o, valid_o;
  logic [DATA_W-1:0] data_o;

  always #2 clk = ~clk;

  adc_serial_reader #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC),
    .SCK_HALF(SCK_HALF), .QUIET_CYC(QUIET_CYC), .CYCLE_MIN(CYCLE_MIN)) i_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o), .conv_o(conv_o),
    .sck_o(sck_o), .sdo_i(sdo_i), .data_o(data_o), .valid_o(valid_o));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model
  logic [DATA_W-1:0] adc_word = '0;
  int oidx = 0;
  always @(negedge conv_o) begin
    oidx = 0;
    sdo_i = adc_word[DATA_W-1];
  end
  always @(negedge sck_o) if (!conv_o) begin
    oidx++;
    sdo_i = (oidx < DATA_W) ? adc_word[DATA_W-1-oidx] : 1'b0;
  end

  // timing observer
  int conv_len = 0, falls = 0, rises = 0, since_fall = 0, sck_bad = 0, valids = 0;
  logic p_conv = 0, p_sck = 1;
  always @(negedge clk) if (rst_n) begin
    if (conv_o && !p_conv) begin conv_len = 0; falls = 0; rises++; end
    if (conv_o) conv_len++;
    if (conv_o && !sck_o) sck_bad++;
    if (p_sck && !sck_o) falls++;
    if (!conv_o && p_conv) since_fall = 0; else since_fall++;
    p_conv = conv_o;
    p_sck  = sck_o;
  end

  // scoreboard
  logic [DATA_W-1:0] exp_q[$];
  always @(negedge clk) if (rst_n && valid_o) begin
    logic [DATA_W-1:0] e;
    valids++;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
    chk(data_o == e, "R5 data", int'(data_o), int'(e));
    chk(conv_len == CONV_CYC, "R2 conv width", conv_len, CONV_CYC);
    chk(falls == DATA_W-1, "R4 sck falls", falls, DATA_W-1);
    chk(sck_o == 1'b1, "R4 sck ends high", int'(sck_o), 1);
    chk(sck_bad == 0, "R3 sck static in conv", sck_bad, 0);
    chk(since_fall == LAT, "R6 strobe latency", since_fall, LAT);
  end

  task automatic run(input logic [DATA_W-1:0] w, input bit poke);
    adc_word = w;
    exp_q.push_back(w);
    while (!ready_o) @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(ready_o == 1'b0, "R7 ready drops", int'(ready_o), 0);
    if (poke) begin
      repeat (50) @(negedge clk);
      start_i = 1;
      repeat (5) @(negedge clk);
      start_i = 0;
    end
    while (!valid_o) @(negedge clk);
    @(negedge clk);
    chk(!valid_o, "R6 one-cycle strobe", int'(valid_o), 0);
    chk(data_o == w, "R6 data held", int'(data_o), int'(w));
  endtask

  int r_before;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(conv_o == 0, "R1 conv", int'(conv_o), 0);
    chk(sck_o == 1, "R1 sck", int'(sck_o), 1);
    chk(valid_o == 0, "R1 valid", int'(valid_o), 0);
    chk(ready_o == 1, "R1 ready", int'(ready_o), 1);
    chk(data_o == 0, "R1 data", int'(data_o), 0);

    run(14'h0000, 0);
    run(14'h3FFF, 0);
    run(14'h2AAA, 1);
    run(14'h1555, 0);
    run(14'h2000, 0);
    run(14'h0001, 1);
    run(14'h2A5C, 0);

    // R7: request right after a result is ignored
    r_before = rises;
    chk(ready_o == 0, "R7 still guarded", int'(ready_o), 0);
    start_i = 1;
    repeat (3) @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    chk(conv_o == 0, "R7 start ignored", int'(conv_o), 0);
    chk(rises == r_before, "R7 no extra conversion", rises, r_before);
    run(14'h1C3E, 0);
    chk(valids == 8, "R7 result count", valids, 8);
    chk(rises == 8, "R7 conversion count", rises, 8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule